// File: doc/BRIEF.md
# I2C Control-Register Slave with Chunked Long Writes

This block lets a system controller reach a bank of control and status registers over a two-wire I2C bus. It runs from a free-running system clock that is independent of any audio master clock, oversamples SCL and SDA, and removes short spikes on both lines. Every transaction starts with the 7-bit device address and the read/write bit, followed by an 8-bit subaddress and then data bytes. Writes leave the block on a registered write port. Reads fetch bytes through a combinational read port.

Subaddresses below a parameterised boundary are byte registers. A multi-byte write to them auto-increments the subaddress after each byte. Subaddresses at or above the boundary are long registers of `LONG_BYTES` bytes. Their data may arrive as several separate transactions, each carrying a multiple of four data bytes. The partial value is held until the full width has arrived, and then it is committed as a single wide write. The slave never holds SCL low. It drives SDA only for its own ACK bits and for read data bits.

Top module: `i2c_chunk_slave`

## Requirements
- R1: The first byte after a START or repeated START carries the device address in bits 7:1 and the direction in bit 0, where 1 means read. On a match with `DEV_ADDR` the slave pulls SDA low in the ninth clock. On a mismatch it leaves SDA released, and the rest of that transaction causes no write.
- R2: A write to a subaddress below `LONG_FIRST` gives one single-cycle `wr_en` pulse per data byte. That pulse has `wr_long`=0, the byte in `wr_data[7:0]` with zero upper bits, and `wr_addr` starting at the subaddress and rising by one per byte.
- R3: After a subaddress write, a repeated START with the read bit returns bytes MSB first from `rd_data` at `rd_addr`. The first byte comes from the written subaddress, and each later byte comes from the next address. A master NACK ends the read, and SDA is released.
- R4: A write to a subaddress at or above `LONG_FIRST` accumulates data bytes, which may span several transactions. When `LONG_BYTES` bytes have arrived, one `wr_en` pulse with `wr_long`=1 carries them, with the earliest byte in the most significant position.
- R5: A long-register transaction whose data byte count is not a multiple of 4 discards the partial assembly when it ends.
- R6: Writing a subaddress that differs from the one being assembled discards the partial assembly.
- R7: A pulse shorter than `FILT_LEN` system clocks on SCL or SDA has no effect on the bus protocol.
- R8: The block has no SCL output. `sda_oe` is asserted only during the slave's ACK bits and during read data bits that are 0. It is released in the clock-low phase after the ACK and is low whenever the bus is idle.
- R9: Reset releases SDA, clears `wr_en` and empties the long-register assembly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| wr_en | output | 1 | Single-cycle write strobe |
| wr_addr | output | 8 | Write subaddress |
| wr_data | output | LONG_BYTES*8 | Write data; byte writes use bits 7:0 |
| wr_long | output | 1 | Strobe carries a full long-register value |
| rd_addr | output | 8 | Subaddress of the byte to be read |
| rd_data | input | 8 | Read data for `rd_addr`, combinational |

## Verification
Byte-register writes are driven from a table of subaddresses, lengths and data values. This separates auto-increment from a fixed address and checks that each byte produces its own strobe. Long-register writes are tried as two 4-byte chunks, as one 8-byte burst, as a chunk sequence broken by a 3-byte transaction, and as a sequence interrupted by another subaddress. These cases separate correct offset retention from the two discard rules and from a premature commit. A read after a repeated START checks subaddress sequencing and MSB-first ordering. A transfer with injected 2-clock spikes on both lines shows whether a spike could be taken as a START or as an extra clock. A wrong device address and a reset in the middle of an assembly cover the remaining edges.

// File: rtl/i2c_chunk_slave.sv
module i2c_chunk_slave #(
  parameter logic [6:0] DEV_ADDR   = 7'h2A,
  parameter int         FILT_LEN   = 3,
  parameter int         LONG_BYTES = 8,
  parameter logic [7:0] LONG_FIRST = 8'h20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  output logic                    wr_en,
  output logic [7:0]              wr_addr,
  output logic [LONG_BYTES*8-1:0] wr_data,
  output logic                    wr_long,
  output logic [7:0]              rd_addr,
  input  logic [7:0]              rd_data
);
  localparam int W  = LONG_BYTES * 8;
  localparam int OW = (LONG_BYTES > 1) ? $clog2(LONG_BYTES) : 1;
  localparam int FW = $clog2(FILT_LEN + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_SUB, S_WR, S_ACK, S_RD, S_MACK, S_RLOAD, S_SKIP
  } st_t;

  logic [1:0]    sy1, sy2, flt, flt_d;
  logic [FW-1:0] fcnt [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1   <= 2'b11;
      sy2   <= 2'b11;
      flt   <= 2'b11;
      flt_d <= 2'b11;
      for (int i = 0; i < 2; i++) fcnt[i] <= '0;
    end else begin
      sy1   <= {sda_i, scl_i};
      sy2   <= sy1;
      flt_d <= flt;
      for (int i = 0; i < 2; i++) begin
        if (sy2[i] != flt[i]) begin
          if (fcnt[i] == FW'(FILT_LEN - 1)) begin
            flt[i]  <= sy2[i];
            fcnt[i] <= '0;
          end else begin
            fcnt[i] <= fcnt[i] + 1'b1;
          end
        end else begin
          fcnt[i] <= '0;
        end
      end
    end
  end

  wire scl_f    = flt[0];
  wire sda_f    = flt[1];
  wire scl_rise = scl_f & ~flt_d[0];
  wire scl_fall = ~scl_f & flt_d[0];
  wire start_c  = scl_f & flt_d[0] & flt_d[1] & ~sda_f;
  wire stop_c   = scl_f & flt_d[0] & ~flt_d[1] & sda_f;

  st_t           state, nxt;
  logic          ack_ok, wlong;
  logic [2:0]    bitcnt;
  logic [7:0]    shreg, sub, asm_sub;
  logic [W-1:0]  asm_q;
  logic [OW-1:0] off;
  logic [1:0]    tcnt;

  wire [7:0] byte_in = {shreg[6:0], sda_f};
  assign rd_addr = sub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      nxt     <= S_IDLE;
      ack_ok  <= 1'b0;
      wlong   <= 1'b0;
      bitcnt  <= '0;
      shreg   <= '0;
      sub     <= '0;
      asm_sub <= '0;
      asm_q   <= '0;
      off     <= '0;
      tcnt    <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_long <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_c || stop_c) begin
        if (wlong && tcnt != 2'd0) off <= '0;
        wlong  <= 1'b0;
        sda_oe <= 1'b0;
        bitcnt <= '0;
        state  <= start_c ? S_DEV : S_IDLE;
      end else begin
        case (state)
          S_DEV, S_SUB, S_WR: if (scl_rise) begin
            shreg  <= byte_in;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 3'd7) begin
              state  <= S_ACK;
              ack_ok <= 1'b1;
              if (state == S_DEV) begin
                ack_ok <= (byte_in[7:1] == DEV_ADDR);
                nxt    <= byte_in[0] ? S_RD : S_SUB;
              end else if (state == S_SUB) begin
                sub  <= byte_in;
                tcnt <= '0;
                nxt  <= S_WR;
                if (byte_in >= LONG_FIRST) begin
                  wlong   <= 1'b1;
                  asm_sub <= byte_in;
                  if (byte_in != asm_sub) off <= '0;
                end else begin
                  wlong <= 1'b0;
                  off   <= '0;
                end
              end else begin
                nxt  <= S_WR;
                tcnt <= tcnt + 1'b1;
                if (wlong) begin
                  asm_q <= {asm_q[W-9:0], byte_in};
                  if (off == OW'(LONG_BYTES - 1)) begin
                    off     <= '0;
                    wr_en   <= 1'b1;
                    wr_long <= 1'b1;
                    wr_addr <= sub;
                    wr_data <= {asm_q[W-9:0], byte_in};
                  end else begin
                    off <= off + 1'b1;
                  end
                end else begin
                  wr_en   <= 1'b1;
                  wr_long <= 1'b0;
                  wr_addr <= sub;
                  wr_data <= {{(W-8){1'b0}}, byte_in};
                  sub     <= sub + 1'b1;
                end
              end
            end
          end
          S_ACK: if (scl_fall) begin
            if (!sda_oe) begin
              if (ack_ok) sda_oe <= 1'b1;
              else state <= S_SKIP;
            end else begin
              bitcnt <= '0;
              if (nxt == S_RD) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                sub    <= sub + 1'b1;
                state  <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= nxt;
              end
            end
          end
          S_RD: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= S_MACK;
            end else begin
              sda_oe <= ~shreg[6];
              shreg  <= {shreg[6:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
          S_MACK: if (scl_rise) state <= sda_f ? S_SKIP : S_RLOAD;
          S_RLOAD: if (scl_fall) begin
            shreg  <= rd_data;
            sda_oe <= ~rd_data[7];
            sub    <= sub + 1'b1;
            bitcnt <= '0;
            state  <= S_RD;
          end
          default: ;
        endcase
      end
    end
  end

  p_oe_where_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state == S_ACK || state == S_RD));
  p_oe_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_c) || $past(stop_c)));
  p_nack_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> !sda_oe);
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_short_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_long) |-> (wr_addr < LONG_FIRST));
  p_long_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_long) |-> (wr_addr >= LONG_FIRST));
  p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_c) |-> (state == S_IDLE && !sda_oe && !wlong));
endmodule

// File: tb/i2c_chunk_slave_tb.sv
module i2c_chunk_slave_tb;
  localparam int Q = 10;
  localparam logic [6:0] DADDR = 7'h2A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, g_scl = 1'b0, g_sda = 1'b0, glitch = 1'b0;
  logic sda_oe, wr_en, wr_long;
  logic [7:0] wr_addr, rd_addr, rd_data;
  logic [63:0] wr_data;

  wire scl_w = scl_m | g_scl;
  wire sda_w = sda_m & ~sda_oe & ~g_sda;
  assign rd_data = rd_addr ^ 8'hA5;

  i2c_chunk_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_long(wr_long),
    .rd_addr(rd_addr), .rd_data(rd_data));

  int checks = 0, errors = 0, lc = 0;
  logic [7:0]  la [16];
  logic [63:0] ld [16];
  logic        ll [16];
  logic        ack;

  always @(negedge clk) if (wr_en) begin
    if (lc < 16) begin la[lc] = wr_addr; ld[lc] = wr_data; ll[lc] = wr_long; end
    lc++;
  end

  localparam logic [17:0] TAB [4] = '{
    {8'h03, 8'h11, 2'd1}, {8'h07, 8'hF0, 2'd2},
    {8'h1C, 8'h5A, 2'd3}, {8'h00, 8'hFE, 2'd3}};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1;
    if (glitch) begin tick(3); g_sda = 1'b1; tick(2); g_sda = 1'b0; tick(2*Q-5); end
    else tick(2*Q);
    scl_m = 1'b0;
    if (glitch) begin tick(5); g_scl = 1'b1; tick(2); g_scl = 1'b0; tick(Q-7); end
    else tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_w; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic a);
    logic t;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(t);
    a = ~t;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] d);
    logic t;
    for (int i = 7; i >= 0; i--) begin bit_in(t); d[i] = t; end
    bit_out(last);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic write_txn(input logic [7:0] sub, input int n, input logic [63:0] v);
    logic a;
    bus_start();
    send_byte({DADDR, 1'b0}, a);
    ack = a;
    send_byte(sub, a);
    for (int k = 0; k < n; k++) send_byte(v[63-8*k -: 8], a);
    bus_stop();
  endtask

  initial begin
    tick(1200000 / 10);
    errors++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] rb;
    tick(5);
    chk(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);
    chk(wr_en == 1'b0, "R9 reset wr_en", wr_en, 0);
    rst_n = 1'b1;
    tick(5);

    for (int e = 0; e < 4; e++) begin
      logic [7:0] s, d0;
      int n;
      s = TAB[e][17:10]; d0 = TAB[e][9:2]; n = int'(TAB[e][1:0]);
      lc = 0;
      write_txn(s, n, {d0, d0 + 8'd1, d0 + 8'd2, 40'h0});
      chk(ack, "R1 address ack", ack, 1);
      chk(lc == n, "R2 strobe count", lc, n);
      for (int k = 0; k < n; k++) begin
        chk(la[k] == s + 8'(k), "R2 address increment", la[k], s + 8'(k));
        chk(ld[k] == {56'h0, d0 + 8'(k)} && !ll[k], "R2 byte data", ld[k], {56'h0, d0 + 8'(k)});
      end
    end

    lc = 0;
    bus_start();
    send_byte({7'h2B, 1'b0}, a);
    chk(!a, "R1 mismatch nack", a, 0);
    send_byte(8'h05, a);
    send_byte(8'h99, a);
    bus_stop();
    chk(lc == 0, "R1 mismatch no write", lc, 0);

    lc = 0;
    bus_start();
    send_byte({DADDR, 1'b0}, a);
    send_byte(8'h10, a);
    bus_start();
    send_byte({DADDR, 1'b1}, a);
    chk(a, "R1 read address ack", a, 1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k == 2, rb);
      chk(rb == ((8'h10 + 8'(k)) ^ 8'hA5), "R3 read byte", rb, (8'h10 + 8'(k)) ^ 8'hA5);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R8 released after read", sda_oe, 0);
    chk(lc == 0, "R3 read causes no write", lc, 0);

    lc = 0;
    write_txn(8'h20, 4, 64'h01020304_00000000);
    chk(lc == 0, "R4 no commit after first chunk", lc, 0);
    write_txn(8'h20, 4, 64'h05060708_00000000);
    chk(lc == 1 && ll[0] && la[0] == 8'h20, "R4 commit after second chunk", lc, 1);
    chk(ld[0] == 64'h01020304_05060708, "R4 assembled value", ld[0], 64'h01020304_05060708);

    lc = 0;
    write_txn(8'h24, 8, 64'h88776655_44332211);
    chk(lc == 1 && ld[0] == 64'h88776655_44332211, "R4 single burst", ld[0], 64'h88776655_44332211);

    lc = 0;
    write_txn(8'h20, 4, 64'hAAAAAAAA_00000000);
    write_txn(8'h20, 3, 64'hBBBBBB00_00000000);
    write_txn(8'h20, 4, 64'hC1C2C3C4_00000000);
    chk(lc == 0, "R5 odd chunk discards", lc, 0);
    write_txn(8'h20, 4, 64'hD1D2D3D4_00000000);
    chk(lc == 1 && ld[0] == 64'hC1C2C3C4_D1D2D3D4, "R5 restart after discard", ld[0], 64'hC1C2C3C4_D1D2D3D4);

    lc = 0;
    write_txn(8'h21, 4, 64'h11111111_00000000);
    write_txn(8'h22, 4, 64'h22222222_00000000);
    chk(lc == 0, "R6 switch subaddress no commit", lc, 0);
    write_txn(8'h22, 4, 64'h33333333_00000000);
    chk(lc == 1 && la[0] == 8'h22, "R6 commit address", la[0], 8'h22);
    chk(ld[0] == 64'h22222222_33333333, "R6 discarded old partial", ld[0], 64'h22222222_33333333);

    lc = 0;
    glitch = 1'b1;
    write_txn(8'h05, 2, 64'hFFBD0000_00000000);
    glitch = 1'b0;
    chk(lc == 2, "R7 glitch strobe count", lc, 2);
    chk(ld[0] == 64'hFF && ld[1] == 64'hBD && la[1] == 8'h06, "R7 glitch data", ld[1], 64'hBD);
    chk(sda_oe == 1'b0, "R8 idle released", sda_oe, 0);

    lc = 0;
    write_txn(8'h20, 4, 64'hE0E0E0E0_00000000);
    rst_n = 1'b0; tick(3);
    chk(sda_oe == 1'b0 && wr_en == 1'b0, "R9 reset outputs", sda_oe, 0);
    rst_n = 1'b1; tick(3);
    write_txn(8'h20, 4, 64'h12345678_00000000);
    chk(lc == 0, "R9 reset emptied assembly", lc, 0);
    write_txn(8'h20, 4, 64'h9ABCDEF0_00000000);
    chk(lc == 1 && ld[0] == 64'h12345678_9ABCDEF0, "R9 post-reset value", ld[0], 64'h12345678_9ABCDEF0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule